// File: doc/BRIEF.md
# Two-Channel Fixed-Priority DMA Bus Arbiter

This block decides which of two independent DMA channel engines may drive a shared bus master interface. Channel 0 always wins a decision over channel 1. A channel that owns the interface keeps it until the master interface reports that the group of transfers handed to it is finished. Only then does the arbiter pick a new owner. A delegated group is at most four 32-bit words. A high-priority request that arrives in the middle of a group therefore waits for that group to drain.

Channel 1 is throttled so that other bus masters can get onto the bus while it is busy. The arbiter counts channel 1 transfers of its programmed size, whatever that size is. On every fourth transfer it withdraws the grant and raises a release indication for exactly one cycle. During that cycle it arbitrates again, and the winner holds the grant on the next cycle. Channel 0 is never forced off the bus. The bus-request output is high whenever a channel holds the grant.

Top module: `dma_pair_arbiter`

## Requirements
- R1: After a synchronous active-low reset, `grant` is 2'b00 and `bus_req` and `bus_release` are 0. The channel-1 transfer count is also zero.
- R2: `grant` is 2'b00 in the cycle after a decision point at which `ch_req` is 2'b00. A decision point is a cycle with no grant, or with no grant and `bus_release` high.
- R3: At a decision point, the grant on the next cycle goes to channel 0 (`grant`=2'b01) whenever `ch_req[0]` is high. It goes to channel 1 (`grant`=2'b10) only when `ch_req` is 2'b10. Bit 0 always refers to channel 0 and bit 1 to channel 1.
- R4: While a channel holds the grant and `grp_done` is low, the grant does not change, even if channel 0 starts requesting. The one exception is the forced release in R7.
- R5: A `grp_done` pulse while a channel is granted is a decision point. The next cycle's grant follows R3 using `ch_req` from the pulse cycle.
- R6: `grant` is never more than one-hot, and `bus_req` is high exactly when `grant` is non-zero.
- R7: The fourth `ch1_beat` counted while channel 1 holds the grant makes the next cycle a release cycle. In a release cycle `grant` is 2'b00, `bus_req` is 0 and `bus_release` is 1. `bus_release` never lasts longer than one cycle. The release takes precedence over a `grp_done` pulse in the same cycle.
- R8: `ch1_beat` pulses have no effect while channel 0 holds the grant or no channel is granted. Channel 0 is never followed by a release cycle.
- R9: The channel-1 transfer count returns to zero whenever channel 1 loses the grant and after each release. A newly granted channel 1 therefore needs four fresh beats before it is released.
- R10: The release cycle is itself a decision point. The grant chosen from `ch_req` in that cycle appears on the very next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ch_req | input | 2 | Per-channel active request, bit 0 = channel 0 |
| grp_done | input | 1 | Master interface finished the owner's delegated transfer group |
| ch1_beat | input | 1 | One channel-1 transfer of its programmed size completed |
| grant | output | 2 | Registered one-hot grant, bit 0 = channel 0 |
| bus_req | output | 1 | Bus request, high while a channel is granted |
| bus_release | output | 1 | High for the single forced release cycle |

## Verification
On every cycle, the assertions check that the grant is at most one-hot and that the release pulse lasts one cycle with everything idle. They also check that channel 0 is never released, that a request from channel 0 always wins an idle decision, and that an owner keeps the grant until its group ends. Only the bench's scenarios and its cycle-by-cycle reference model can show the counting behaviour. That covers releasing on exactly the fourth beat, clearing the count when channel 1 loses the grant, ignoring beats while channel 0 owns the bus, and the release winning over a simultaneous group end.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
   localparam int unsigned ARB_CHANNELS = 2;
   localparam int unsigned ARB_LOW_CH   = ARB_CHANNELS - 1;
   typedef logic [ARB_CHANNELS-1:0] chan_vec_t;
endpackage

// File: rtl/dma_arb_prio_pick.sv
// Fixed-priority picker: the lowest index with a request wins.
module dma_arb_prio_pick #(
   parameter int unsigned N = 2
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] pick
);
   if (N < 1) begin : g_bad_n
      $error("dma_arb_prio_pick: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_pick
      if (i == 0) begin : g_top
         assign pick[i] = req[i];
      end else begin : g_rest
         assign pick[i] = req[i] & ~(|req[i-1:0]);
      end
   end
endmodule

// File: rtl/dma_arb_release_ctr.sv
// Counts transfers of the throttled channel and flags the one that forces a release.
module dma_arb_release_ctr #(
   parameter int unsigned BEATS_PER_RELEASE = 4,
   parameter bit          THROTTLE_EN       = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic beat,
   input  logic clear,
   output logic hit
);
   localparam int unsigned CNT_W = (BEATS_PER_RELEASE > 2) ? $clog2(BEATS_PER_RELEASE) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(BEATS_PER_RELEASE - 1);

   if (BEATS_PER_RELEASE < 2) begin : g_bad_beats
      $error("dma_arb_release_ctr: BEATS_PER_RELEASE must be at least 2");
   end

   if (THROTTLE_EN) begin : g_throttle
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (clear) begin
            cnt_q <= '0;
         end else if (active && beat) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end

      assign hit = active & beat & (cnt_q == LAST);
   end else begin : g_free
      assign hit = 1'b0;
   end
endmodule

// File: rtl/dma_pair_arbiter.sv
// Two-channel fixed-priority arbiter with group-boundary switching
// and a forced one-cycle release for the low-priority channel.
module dma_pair_arbiter
   import dma_arb_pkg::*;
#(
   parameter int unsigned NUM_CH            = 2,
   parameter int unsigned BEATS_PER_RELEASE = 4,
   parameter bit          THROTTLE_EN       = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] ch_req,
   input  logic       grp_done,
   input  logic       ch1_beat,
   output logic [1:0] grant,
   output logic       bus_req,
   output logic       bus_release
);
   localparam int unsigned LOW_CH = NUM_CH - 1;

   if (NUM_CH != ARB_CHANNELS) begin : g_bad_ch
      $error("dma_pair_arbiter: NUM_CH must equal 2");
   end

   chan_vec_t gnt_q, gnt_d, pick;
   logic      rel_q, rel_d;
   logic      hit;
   logic      low_active;
   logic      low_clear;

   dma_arb_prio_pick #(.N(ARB_CHANNELS)) u_pick (
      .req  (ch_req),
      .pick (pick)
   );

   assign low_active = gnt_q[LOW_CH] & ~rel_q;
   assign low_clear  = ~gnt_d[LOW_CH];

   dma_arb_release_ctr #(
      .BEATS_PER_RELEASE (BEATS_PER_RELEASE),
      .THROTTLE_EN       (THROTTLE_EN)
   ) u_rel (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (low_active),
      .beat   (ch1_beat),
      .clear  (low_clear),
      .hit    (hit)
   );

   always_comb begin
      rel_d = 1'b0;
      gnt_d = gnt_q;
      if (rel_q || (gnt_q == '0)) begin
         gnt_d = pick;
      end else if (hit) begin
         gnt_d = '0;
         rel_d = 1'b1;
      end else if (grp_done) begin
         gnt_d = pick;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gnt_q <= '0;
         rel_q <= 1'b0;
      end else begin
         gnt_q <= gnt_d;
         rel_q <= rel_d;
      end
   end

   assign grant       = gnt_q;
   assign bus_req     = |gnt_q;
   assign bus_release = rel_q;
endmodule

// File: rtl/dma_pair_arbiter_chk.sv
module dma_pair_arbiter_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] ch_req,
   input logic       grp_done,
   input logic       ch1_beat,
   input logic [1:0] grant,
   input logic       bus_req,
   input logic       bus_release
);
   // R6: grant is at most one-hot
   p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   // R6: the bus is requested exactly while a channel is granted
   p_busreq_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (grant != 2'b00) == bus_req);

   // R7: the release cycle is idle and lasts one cycle
   p_release_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      bus_release |-> (grant == 2'b00) && !bus_req);
   p_release_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      bus_release |=> !bus_release);
   p_release_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_release) |-> $past(grant[1] && ch1_beat));

   // R8: channel 0 is never released
   p_no_release_ch0_r8: assert property (@(posedge clk) disable iff (!rst_n)
      grant[0] |=> !bus_release);

   // R2: no request at a decision point gives no grant
   p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (grant == 2'b00) && (ch_req == 2'b00) |=> (grant == 2'b00));

   // R3 / R10: channel 0 wins every decision made without an owner
   p_prio_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (grant == 2'b00) && ch_req[0] |=> grant == 2'b01);

   // R4: owners hold the grant until the group ends
   p_hold_ch0_r4: assert property (@(posedge clk) disable iff (!rst_n)
      grant[0] && !grp_done |=> grant[0]);
   p_hold_ch1_r4: assert property (@(posedge clk) disable iff (!rst_n)
      grant[1] && !grp_done && !ch1_beat |=> grant[1]);
endmodule

bind dma_pair_arbiter dma_pair_arbiter_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ch_req      (ch_req),
   .grp_done    (grp_done),
   .ch1_beat    (ch1_beat),
   .grant       (grant),
   .bus_req     (bus_req),
   .bus_release (bus_release)
);

// File: tb/dma_pair_arbiter_bench.sv
`timescale 1ns/1ps
module dma_pair_arbiter_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] ch_req = 2'b00;
   logic       grp_done = 1'b0;
   logic       ch1_beat = 1'b0;
   logic [1:0] grant;
   logic       bus_req;
   logic       bus_release;

   int checks = 0;
   int failures = 0;

   // reference model state
   int m_g = 0;    // 0 none, 1 ch0, 2 ch1 (same as grant bit mask)
   int m_c = 0;
   int m_r = 0;

   always #5 clk = ~clk;

   dma_pair_arbiter u_dma_pair_arbiter (
      .clk         (clk),
      .rst_n       (rst_n),
      .ch_req      (ch_req),
      .grp_done    (grp_done),
      .ch1_beat    (ch1_beat),
      .grant       (grant),
      .bus_req     (bus_req),
      .bus_release (bus_release)
   );

   function automatic int pick_of(input logic [1:0] r);
      if (r[0]) return 1;
      if (r[1]) return 2;
      return 0;
   endfunction

   always @(posedge clk) begin
      int ng, nc, nr;
      if (!rst_n) begin
         m_g = 0; m_c = 0; m_r = 0;
      end else begin
         nc = m_c; nr = 0;
         if (m_r != 0 || m_g == 0) ng = pick_of(ch_req);
         else if (m_g == 2 && ch1_beat && m_c == 3) begin ng = 0; nr = 1; end
         else if (grp_done) ng = pick_of(ch_req);
         else ng = m_g;
         if (m_g == 2 && m_r == 0 && ch1_beat) nc = m_c + 1;
         if (ng != 2) nc = 0;
         m_g = ng; m_c = nc; m_r = nr;
      end
   end

   // per-cycle comparison against the model (R6, R7 and all grant behaviour)
   always @(negedge clk) begin
      if (rst_n) begin
         checks++;
         if (grant !== 2'(m_g) || bus_req !== (m_g != 0) || bus_release !== (m_r != 0)) begin
            failures++;
            $display("FAIL R6 model mismatch at %0t: grant=%b req=%b rel=%b expected grant=%0d req=%0d rel=%0d",
                     $time, grant, bus_req, bus_release, m_g, (m_g != 0), m_r);
         end
      end
   end

   task automatic chk(input string tag, input logic [1:0] g_exp, input logic rel_exp);
      checks++;
      if (grant !== g_exp || bus_release !== rel_exp || bus_req !== (g_exp != 2'b00)) begin
         failures++;
         $display("FAIL %s: grant=%b rel=%b req=%b expected grant=%b rel=%b", tag,
                  grant, bus_release, bus_req, g_exp, rel_exp);
      end
   endtask

   task automatic step(input logic [1:0] r, input logic d, input logic b);
      ch_req = r; grp_done = d; ch1_beat = b;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic run_all;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk("R1 reset state", 2'b00, 1'b0);
      step(2'b00, 1'b0, 1'b1);
      chk("R2 idle no grant", 2'b00, 1'b0);
      step(2'b10, 1'b0, 1'b0);
      chk("R3 ch1 alone granted", 2'b10, 1'b0);
      step(2'b11, 1'b0, 1'b1);
      step(2'b11, 1'b0, 1'b1);
      step(2'b11, 1'b0, 1'b0);
      chk("R4 ch1 holds while ch0 waits", 2'b10, 1'b0);
      step(2'b11, 1'b0, 1'b1);
      chk("R4 ch1 holds after third beat", 2'b10, 1'b0);
      step(2'b11, 1'b0, 1'b1);
      chk("R7 release after fourth beat", 2'b00, 1'b1);
      step(2'b11, 1'b0, 1'b0);
      chk("R10 grant right after release", 2'b01, 1'b0);
      for (int i = 0; i < 5; i++) step(2'b11, 1'b0, 1'b1);
      chk("R8 beats ignored under ch0", 2'b01, 1'b0);
      step(2'b10, 1'b1, 1'b0);
      chk("R5 group end re-arbitrates", 2'b10, 1'b0);
      step(2'b10, 1'b0, 1'b1);
      step(2'b10, 1'b0, 1'b1);
      step(2'b11, 1'b1, 1'b0);
      chk("R3 ch0 wins at group end", 2'b01, 1'b0);
      step(2'b10, 1'b1, 1'b0);
      chk("R5 ch1 regains grant", 2'b10, 1'b0);
      step(2'b10, 1'b0, 1'b1);
      step(2'b10, 1'b0, 1'b1);
      step(2'b10, 1'b0, 1'b1);
      chk("R9 count restarted on loss", 2'b10, 1'b0);
      step(2'b10, 1'b1, 1'b1);
      chk("R7 release beats group end", 2'b00, 1'b1);
      step(2'b00, 1'b0, 1'b0);
      chk("R10 empty decision in release", 2'b00, 1'b0);
      step(2'b01, 1'b0, 1'b0);
      step(2'b00, 1'b1, 1'b0);
      chk("R2 ch0 group end with no request", 2'b00, 1'b0);
      for (int i = 0; i < 400; i++) begin
         step(2'($urandom), ($urandom % 3) == 0, ($urandom % 2) == 0);
      end
      step(2'b00, 1'b1, 1'b0);
      step(2'b00, 1'b1, 1'b0);
      chk("R2 drained to idle", 2'b00, 1'b0);
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (20000) @(posedge clk);
            failures++;
            $display("FAIL watchdog expired");
         end
      join_any
      disable fork;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule